// File: doc/BRIEF.md
# Atomic Read-Modify-Write Shared Memory Unit

This block is a small shared word store that several requesters reach through one arbitrated port. Besides ordinary loads and stores it carries out three indivisible operations: test-and-set, exchange and compare-and-swap. Software running on the requesters builds spin locks and lock-free updates on these operations.

Each requester presents a request with an opcode, a word address, a write operand and a compare operand. It holds the request until its grant bit pulses. A round-robin arbiter picks one requester at a time. The chosen operation then owns the memory port until its write-back is done, so no other request can slip between the read and the write of an atomic operation.

Every granted request produces exactly one response pulse. The pulse carries the index of the requester, the word that was in memory before the operation, and a status flag.

Top module: `amu_top`

## Requirements
- R1: On synchronous reset every memory word becomes zero and no grant or response is raised. After reset requester 0 has the highest priority.
- R2: At most one grant bit is high in a cycle, and only for a requester whose valid is high. The search for a winner starts at the index after the last granted requester and wraps around.
- R3: Opcode 0 (load) returns the addressed word with flag 1 and leaves memory unchanged.
- R4: Opcode 1 (store) writes the write operand, returns the previous word with flag 1. Storing 0 releases a lock.
- R5: Opcode 2 (test-and-set) returns the previous word and writes 1. The flag is 1 exactly when the previous word was 0, meaning the lock was taken. Any nonzero previous word gives flag 0.
- R6: Opcode 3 (exchange) writes the write operand and returns the previous word with flag 1.
- R7: Opcode 4 (compare-and-swap) writes the write operand only when the addressed word equals the compare operand. It returns the previous word, with flag 1 on a match and 0 otherwise.
- R8: Opcodes 5, 6 and 7 behave as a load: they return the word with flag 1 and write nothing.
- R9: After a grant no further grant is issued for the next two cycles. The response pulse comes exactly three cycles after its grant, lasts one cycle and carries the granted requester's index.
- R10: When several requesters apply test-and-set to the same free word in the same cycle, exactly one of them gets flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ (4) | Per-requester request valid, held until granted |
| req_op | input | NREQ*3 (12) | Per-requester opcode, 3 bits each |
| req_addr | input | NREQ*AW (24) | Per-requester word address |
| req_wdata | input | NREQ*DW (128) | Per-requester write / new value operand |
| req_cmp | input | NREQ*DW (128) | Per-requester compare operand |
| req_gnt | output | NREQ (4) | One-hot grant pulse, request accepted this cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_id | output | IW (2) | Index of the requester being answered |
| rsp_old | output | DW (32) | Memory word before the operation |
| rsp_flag | output | 1 | Status flag as defined per opcode |

## Verification
The assertions assume that a requester keeps its valid and operands steady until its grant bit pulses, then drops valid in the next cycle. The latency and identity checks take the grant cycle as the cycle in which the operands are captured. The stimulus keeps to this rule: requests are applied at the falling edge, and valid is withdrawn at the falling edge that follows the grant. No stimulus lets a requester re-issue while its earlier request is still in flight.

// File: rtl/amu_pkg.sv
package amu_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_TAS   = 3'd2,
        OP_SWAP  = 3'd3,
        OP_CAS   = 3'd4
    } amu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_COMMIT = 2'd2
    } amu_state_e;

    localparam int OP_W = 3;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/amu_rr_arb.sv
module amu_rr_arb
    import amu_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);

    logic [IW-1:0] last_q;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last_q) + k) % N;
            if (!any && req[c]) begin
                any     = 1'b1;
                gnt[c]  = 1'b1;
                gnt_idx = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(N - 1);
        end else if (any) begin
            last_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/amu_opunit.sv
module amu_opunit
    import amu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   old,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   cmp,
    output logic            wr,
    output logic [DW-1:0]   nxt,
    output logic            flag
);

    logic match;
    assign match = (old == cmp);

    always_comb begin
        wr   = 1'b0;
        nxt  = old;
        flag = 1'b1;
        case (op)
            OP_STORE: begin
                wr  = 1'b1;
                nxt = wdata;
            end
            OP_TAS: begin
                wr   = 1'b1;
                nxt  = DW'(1);
                flag = (old == '0);
            end
            OP_SWAP: begin
                wr  = 1'b1;
                nxt = wdata;
            end
            OP_CAS: begin
                wr   = match;
                nxt  = wdata;
                flag = match;
            end
            default: begin
                wr   = 1'b0;
                nxt  = old;
                flag = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/amu_mem.sv
module amu_mem #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] words [DEPTH];

    assign rdata = words[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

endmodule

// File: rtl/amu_top.sv
module amu_top
    import amu_pkg::*;
#(
    parameter int NREQ  = 4,
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IW   = idx_width(NREQ)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NREQ-1:0]      req_valid,
    input  logic [NREQ*OP_W-1:0] req_op,
    input  logic [NREQ*AW-1:0]   req_addr,
    input  logic [NREQ*DW-1:0]   req_wdata,
    input  logic [NREQ*DW-1:0]   req_cmp,
    output logic [NREQ-1:0]      req_gnt,
    output logic                 rsp_valid,
    output logic [IW-1:0]        rsp_id,
    output logic [DW-1:0]        rsp_old,
    output logic                 rsp_flag
);

    amu_state_e      state_q;
    logic [IW-1:0]   cur_id_q;
    logic [OP_W-1:0] cur_op_q;
    logic [AW-1:0]   cur_addr_q;
    logic [DW-1:0]   cur_wd_q;
    logic [DW-1:0]   cur_cmp_q;
    logic [DW-1:0]   old_q;

    logic [NREQ-1:0] arb_req;
    logic [IW-1:0]   win_idx;
    logic            win_any;
    logic [DW-1:0]   mem_rdata;
    logic            op_wr;
    logic [DW-1:0]   op_nxt;
    logic            op_flag;
    logic            mem_we;

    // Requests are only offered to the arbiter while the port is free.
    assign arb_req = (state_q == ST_IDLE) ? req_valid : '0;

    amu_rr_arb #(.N(NREQ)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (arb_req),
        .gnt     (req_gnt),
        .gnt_idx (win_idx),
        .any     (win_any)
    );

    amu_opunit #(.DW(DW)) u_op (
        .op    (cur_op_q),
        .old   (old_q),
        .wdata (cur_wd_q),
        .cmp   (cur_cmp_q),
        .wr    (op_wr),
        .nxt   (op_nxt),
        .flag  (op_flag)
    );

    assign mem_we = (state_q == ST_COMMIT) && op_wr;

    amu_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (cur_addr_q),
        .wdata (op_nxt),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cur_id_q   <= '0;
            cur_op_q   <= '0;
            cur_addr_q <= '0;
            cur_wd_q   <= '0;
            cur_cmp_q  <= '0;
            old_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_id     <= '0;
            rsp_old    <= '0;
            rsp_flag   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (win_any) begin
                        cur_id_q   <= win_idx;
                        cur_op_q   <= req_op[win_idx*OP_W +: OP_W];
                        cur_addr_q <= req_addr[win_idx*AW +: AW];
                        cur_wd_q   <= req_wdata[win_idx*DW +: DW];
                        cur_cmp_q  <= req_cmp[win_idx*DW +: DW];
                        state_q    <= ST_READ;
                    end
                end
                ST_READ: begin
                    old_q   <= mem_rdata;
                    state_q <= ST_COMMIT;
                end
                ST_COMMIT: begin
                    rsp_valid <= 1'b1;
                    rsp_id    <= cur_id_q;
                    rsp_old   <= old_q;
                    rsp_flag  <= op_flag;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: grant is one-hot and only for a valid requester
    a_r2_onehot_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_gnt));
    a_r2_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (req_gnt & ~req_valid) == '0);
    // R9: port stays locked for the read and the write-back of a granted op
    a_r9_port_locked: assert property (@(posedge clk) disable iff (rst)
        (|req_gnt) |=> (req_gnt == '0) ##1 (req_gnt == '0));
    // R9: response three cycles after the grant
    a_r9_rsp_latency: assert property (@(posedge clk) disable iff (rst)
        (|req_gnt) |-> ##3 rsp_valid);
    // R9: response names the requester granted three cycles earlier
    a_r9_rsp_id: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_id == $past(win_idx, 3)));
    // R9: response is a single-cycle pulse
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/test_amu_top.sv
module test_amu_top;

    localparam int NREQ = 4;
    localparam int DW   = 32;
    localparam int AW   = 6;
    localparam int IW   = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NREQ-1:0]      req_valid = '0;
    logic [NREQ*3-1:0]    req_op = '0;
    logic [NREQ*AW-1:0]   req_addr = '0;
    logic [NREQ*DW-1:0]   req_wdata = '0;
    logic [NREQ*DW-1:0]   req_cmp = '0;
    logic [NREQ-1:0]      req_gnt;
    logic                 rsp_valid;
    logic [IW-1:0]        rsp_id;
    logic [DW-1:0]        rsp_old;
    logic                 rsp_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    amu_top #(.NREQ(NREQ), .DW(DW), .DEPTH(64)) i_amu_top (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_cmp   (req_cmp),
        .req_gnt   (req_gnt),
        .rsp_valid (rsp_valid),
        .rsp_id    (rsp_id),
        .rsp_old   (rsp_old),
        .rsp_flag  (rsp_flag)
    );

    typedef struct packed {
        logic [1:0]  id;
        logic [2:0]  op;
        logic [5:0]  addr;
        logic [31:0] wd;
        logic [31:0] cmp;
        logic [31:0] old;
        logic        flag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 3'd0, 6'd5,  32'h0,        32'h0,        32'h0,        1'b1}, // R3 R1 zero after reset
        '{2'd1, 3'd2, 6'd5,  32'h0,        32'h0,        32'h0,        1'b1}, // R5 lock taken
        '{2'd2, 3'd2, 6'd5,  32'h0,        32'h0,        32'h1,        1'b0}, // R5 lock busy
        '{2'd3, 3'd0, 6'd5,  32'h0,        32'h0,        32'h1,        1'b1}, // R3
        '{2'd0, 3'd1, 6'd5,  32'h0,        32'h0,        32'h1,        1'b1}, // R4 release
        '{2'd1, 3'd2, 6'd5,  32'h0,        32'h0,        32'h0,        1'b1}, // R5 retake after release
        '{2'd2, 3'd3, 6'd10, 32'hDEADBEEF, 32'h0,        32'h0,        1'b1}, // R6
        '{2'd3, 3'd3, 6'd10, 32'h12345678, 32'h0,        32'hDEADBEEF, 1'b1}, // R6
        '{2'd0, 3'd4, 6'd10, 32'hAAAA5555, 32'h11111111, 32'h12345678, 1'b0}, // R7 mismatch
        '{2'd1, 3'd0, 6'd10, 32'h0,        32'h0,        32'h12345678, 1'b1}, // R7 unchanged
        '{2'd2, 3'd4, 6'd10, 32'hCAFEF00D, 32'h12345678, 32'h12345678, 1'b1}, // R7 match
        '{2'd3, 3'd0, 6'd10, 32'h0,        32'h0,        32'hCAFEF00D, 1'b1}, // R7 written
        '{2'd0, 3'd1, 6'd63, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b1}, // R4 top address
        '{2'd1, 3'd2, 6'd63, 32'h0,        32'h0,        32'hFFFFFFFF, 1'b0}, // R5 nonzero busy
        '{2'd2, 3'd0, 6'd63, 32'h0,        32'h0,        32'h1,        1'b1}, // R5 wrote 1
        '{2'd3, 3'd7, 6'd10, 32'h5,        32'h0,        32'hCAFEF00D, 1'b1}, // R8
        '{2'd0, 3'd0, 6'd10, 32'h0,        32'h0,        32'hCAFEF00D, 1'b1}, // R8 no write
        '{2'd1, 3'd0, 6'd0,  32'h0,        32'h0,        32'h0,        1'b1}  // R3 untouched word
    };

    function automatic string req_of_op(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input int id, input logic [2:0] op, input logic [5:0] addr,
                         input logic [31:0] wd, input logic [31:0] cmp);
        req_op[id*3 +: 3]     = op;
        req_addr[id*AW +: AW] = addr;
        req_wdata[id*DW +: DW] = wd;
        req_cmp[id*DW +: DW]  = cmp;
        req_valid[id]         = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = '0;
        repeat (3) @(negedge clk);
        check(req_gnt == '0, "R1", "grant during reset", 32'(req_gnt), 32'h0);
        check(rsp_valid == 1'b0, "R1", "response during reset", 32'(rsp_valid), 32'h0);
        rst = 1'b0;
    endtask

    task automatic run_one(input vec_t v);
        int lat;
        string rq;
        rq = req_of_op(v.op);
        @(negedge clk);
        drive(int'(v.id), v.op, v.addr, v.wd, v.cmp);
        #1;
        while (!req_gnt[v.id]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid[v.id] = 1'b0;
        lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 3, "R9", "grant-to-response latency", 32'(lat), 32'd3);
        check(rsp_id == v.id, "R9", "response id", 32'(rsp_id), 32'(v.id));
        check(rsp_old == v.old, rq, "old word", rsp_old, v.old);
        check(rsp_flag == v.flag, rq, "flag", 32'(rsp_flag), 32'(v.flag));
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9", "response pulse length", 32'(rsp_valid), 32'h0);
    endtask

    int          ord [8];
    int          n_ord;
    logic [31:0] got_old [NREQ];
    logic        got_flag [NREQ];
    int          n_rsp;

    // Apply all requests in the same cycle, record grant order and responses.
    task automatic contend(input int n_exp);
        logic [NREQ-1:0] drop;
        drop  = '0;
        n_ord = 0;
        n_rsp = 0;
        for (int cyc = 0; cyc < 60 && n_rsp < n_exp; cyc++) begin
            #1;
            for (int i = 0; i < NREQ; i++) begin
                if (req_gnt[i]) begin
                    if (n_ord < 8) ord[n_ord] = i;
                    n_ord++;
                    drop[i] = 1'b1;
                end
            end
            if (rsp_valid) begin
                got_old[rsp_id]  = rsp_old;
                got_flag[rsp_id] = rsp_flag;
                n_rsp++;
            end
            @(negedge clk);
            req_valid = req_valid & ~drop;
            drop = '0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog expired: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();

        for (int k = 0; k < NV; k++) begin
            run_one(TBL[k]);
        end

        // R1: a second reset clears the written words
        do_reset();
        run_one('{2'd2, 3'd0, 6'd10, 32'h0, 32'h0, 32'h0, 1'b1});
        run_one('{2'd3, 3'd0, 6'd63, 32'h0, 32'h0, 32'h0, 1'b1});

        // R1 R2 R10: fresh reset, all four requesters at once
        do_reset();
        @(negedge clk);
        drive(0, 3'd2, 6'd20, 32'h0, 32'h0);
        drive(1, 3'd2, 6'd20, 32'h0, 32'h0);
        drive(2, 3'd0, 6'd20, 32'h0, 32'h0);
        drive(3, 3'd2, 6'd20, 32'h0, 32'h0);
        contend(4);
        check(n_ord == 4, "R2", "grant count", 32'(n_ord), 32'd4);
        for (int i = 0; i < 4; i++) begin
            check(ord[i] == i, "R2", "grant order after reset", 32'(ord[i]), 32'(i));
        end
        check(got_flag[0] == 1'b1 && got_old[0] == 0, "R10", "first test-and-set wins",
              {got_old[0][30:0], got_flag[0]}, 32'h1);
        check(got_flag[1] == 1'b0 && got_old[1] == 1, "R10", "second test-and-set loses",
              {got_old[1][30:0], got_flag[1]}, 32'h2);
        check(got_old[2] == 1, "R5", "lock word holds 1", got_old[2], 32'h1);
        check(got_flag[3] == 1'b0, "R10", "later test-and-set loses", 32'(got_flag[3]), 32'h0);

        // R2: last grant was 3; grant 2 alone, then 1 and 3 together -> 3 then 1
        @(negedge clk);
        drive(2, 3'd0, 6'd1, 32'h0, 32'h0);
        contend(1);
        check(n_ord == 1 && ord[0] == 2, "R2", "single grant", 32'(ord[0]), 32'd2);
        drive(1, 3'd0, 6'd1, 32'h0, 32'h0);
        drive(3, 3'd0, 6'd1, 32'h0, 32'h0);
        contend(2);
        check(n_ord == 2, "R2", "pair grant count", 32'(n_ord), 32'd2);
        check(ord[0] == 3, "R2", "rotation first", 32'(ord[0]), 32'd3);
        check(ord[1] == 1, "R2", "rotation second", 32'(ord[1]), 32'd1);

        // R4: release the contested lock, then it can be taken again
        run_one('{2'd1, 3'd1, 6'd20, 32'h0, 32'h0, 32'h1, 1'b1});
        run_one('{2'd2, 3'd2, 6'd20, 32'h0, 32'h0, 32'h0, 1'b1});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule